// File: doc/BRIEF.md
# Time-of-Year Clock with Register Bus

This block keeps the time of year. A 32.768 kHz oscillator tick, which arrives as a one-cycle enable pulse in the bus clock domain, is divided down to seconds by a programmable trim divisor. The running time sits in two words. A packed calendar word holds seconds, minutes, hours, day of month and month. A separate 32-bit word holds the plain calendar year. Seconds carry through minutes, hours, days and months into the year, and the carry follows each month's length and the Gregorian leap-year rule.

Software uses a small register bus. It writes the trim divisor and the time, and it reads back the time and a status word. A write to the trim or to the time registers does not reach the running counter at once. It is held, and it is loaded on the second oscillator tick after the write. This models the handshake into the slow domain. While a load is pending, a busy bit in the status word is set. A new write to the same register group during that window is dropped. Reading the calendar word also takes a snapshot of the year, so a calendar read followed by a year read gives one coherent time even when a carry happens between the two reads.

Top module: `toy_clock`

## Requirements
- R1: After reset the time is year 1900, month 1, day 1, 00:00:00 (calendar read 0x0420_0000, year read 1900), and the status word reads 0. The counter stays stopped, whatever ticks arrive, until the first trim write has been loaded.
- R2: Byte offsets:
  - 0x00 trim (read returns the applied trim).
  - 0x04 calendar write.
  - 0x08 year write.
  - 0x0C calendar read.
  - 0x10 year read.
  - 0x20 status.
  - All other offsets, including 0x14/0x18/0x1C, read as 0 and ignore writes. Reading 0x04 or 0x08 also returns 0.
- R3: Calendar word fields: month [31:26] (1..12), day [25:21], hour [20:16], minute [15:10], second [9:4]. Bits [3:0] hold whatever was written and never change by counting.
- R4: Once a trim value T has been loaded, the second advances once every T+1 oscillator ticks, counted from the load. The first trim load sets status bits 8 and 5, and they stay set.
- R5: Status bit 4 (trim busy) is set from the cycle after a trim write until the second tick after it, when the new trim is applied. A trim write while bit 4 is set is ignored.
- R6: Status bit 0 (time busy) is set from the cycle after a calendar or year write until the second tick after it. At that tick the written word replaces the running one, and this load takes priority over counting for that word.
- R7: A calendar or year write while status bit 0 is set is ignored.
- R8: Seconds and minutes roll from 59 to 0, and hours roll from 23 to 0, each carrying into the next field. The day increments when hours roll over.
- R9: The day rolls to 1 after the month's last day. April, June, September and November have 30 days. February has 29 days in years divisible by 4 but not by 100 unless also by 400, and 28 days otherwise. Other months have 31 days. Month 12 rolls to 1 and increments the year.
- R10: The year read returns the year as it stood when the calendar word was last read (1900 before any calendar read).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| osc_tick_i | input | 1 | One-cycle pulse per 32.768 kHz oscillator period |
| req_i | input | 1 | Bus access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 6 | Byte offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i (combinational) |

## Verification
A behavioural model compares every register value on every clock. Directed scenarios drive the tick in three ways: no ticks at all, which shows that writes stay pending and the time stays frozen; one tick per cycle, which separates the two-tick load from counting; and sparse ticks with gaps, which shows the divider counts ticks and not clock cycles. The calendar is started just before each boundary in turn: the minute/hour carry, the 30-day month, February in 2000, 2024, 2023 and 2100, and the year end. This separates the correct leap rule from the simpler divisible-by-4 rule. A year read issued after a rollover but before a new calendar read shows the coherent snapshot.

// File: rtl/toy_clock_pkg.sv
package toy_clock_pkg;
  localparam int unsigned ADDR_W = 6;
  localparam logic [ADDR_W-1:0] OFF_TRIM   = 6'h00;
  localparam logic [ADDR_W-1:0] OFF_CAL_WR = 6'h04;
  localparam logic [ADDR_W-1:0] OFF_YR_WR  = 6'h08;
  localparam logic [ADDR_W-1:0] OFF_CAL_RD = 6'h0C;
  localparam logic [ADDR_W-1:0] OFF_YR_RD  = 6'h10;
  localparam logic [ADDR_W-1:0] OFF_STAT   = 6'h20;

  localparam int unsigned ST_TIME_BUSY = 0;
  localparam int unsigned ST_TRIM_BUSY = 4;
  localparam int unsigned ST_OSC_OK    = 5;
  localparam int unsigned ST_RUN       = 8;

  typedef struct packed {
    logic [5:0] mon;
    logic [4:0] day;
    logic [4:0] hr;
    logic [5:0] min;
    logic [5:0] sec;
    logic [3:0] pad;
  } cal_t;

  localparam cal_t CAL_RESET = '{mon: 6'd1, day: 5'd1, hr: 5'd0, min: 6'd0, sec: 6'd0, pad: 4'd0};
  localparam logic [31:0] YEAR_RESET = 32'd1900;

  function automatic logic leap_year(input logic [31:0] y);
    return (y[1:0] == 2'b00) && (((y % 32'd100) != 32'd0) || ((y % 32'd400) == 32'd0));
  endfunction

  function automatic logic [4:0] last_day(input logic [5:0] m, input logic [31:0] y);
    unique case (m)
      6'd2:                     return leap_year(y) ? 5'd29 : 5'd28;
      6'd4, 6'd6, 6'd9, 6'd11:  return 5'd30;
      default:                  return 5'd31;
    endcase
  endfunction
endpackage

// File: rtl/toy_clock_xfer.sv
// Holds a written word and releases it on the SYNC_TICKS-th oscillator tick.
module toy_clock_xfer #(
  parameter int unsigned W          = 16,
  parameter int unsigned SYNC_TICKS = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  input  logic         tick_i,
  output logic         busy_o,
  output logic         load_o,
  output logic [W-1:0] data_o
);
  localparam int unsigned CW = (SYNC_TICKS > 1) ? $clog2(SYNC_TICKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(SYNC_TICKS - 1);

  logic          busy_q;
  logic [CW-1:0] cnt_q;
  logic [W-1:0]  data_q;

  assign load_o = busy_q && tick_i && (cnt_q == LAST);
  assign busy_o = busy_q;
  assign data_o = data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      data_q <= '0;
    end else if (load_o) begin
      busy_q <= 1'b0;
    end else if (busy_q) begin
      if (tick_i) cnt_q <= cnt_q + 1'b1;
    end else if (wr_i) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
      data_q <= wdata_i;
    end
  end

  a_r6_busy_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !tick_i) |=> busy_q);
  a_r7_no_overwrite: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && wr_i) |=> $stable(data_q));
endmodule

// File: rtl/toy_clock_prescaler.sv
module toy_clock_prescaler #(
  parameter int unsigned TRIM_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              en_i,
  input  logic              load_i,
  input  logic [TRIM_W-1:0] trim_i,
  output logic              sec_o
);
  logic [TRIM_W-1:0] cnt_q;

  assign sec_o = en_i && tick_i && !load_i && (cnt_q == trim_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= '0;
    else if (en_i && tick_i) cnt_q <= sec_o ? '0 : cnt_q + 1'b1;
  end

  a_r4_cnt_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= trim_i);
endmodule

// File: rtl/toy_clock_calendar.sv
module toy_clock_calendar
  import toy_clock_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        adv_i,
  input  logic        ld_cal_i,
  input  cal_t        cal_i,
  input  logic        ld_yr_i,
  input  logic [31:0] yr_i,
  output cal_t        cal_o,
  output logic [31:0] yr_o
);
  cal_t        cal_q, cal_d;
  logic [31:0] yr_q, yr_d;

  always_comb begin
    cal_d = cal_q;
    yr_d  = yr_q;
    if (adv_i) begin
      if (cal_q.sec >= 6'd59) begin
        cal_d.sec = '0;
        if (cal_q.min >= 6'd59) begin
          cal_d.min = '0;
          if (cal_q.hr >= 5'd23) begin
            cal_d.hr = '0;
            if (cal_q.day >= last_day(cal_q.mon, yr_q)) begin
              cal_d.day = 5'd1;
              if (cal_q.mon >= 6'd12) begin
                cal_d.mon = 6'd1;
                yr_d      = yr_q + 32'd1;
              end else begin
                cal_d.mon = cal_q.mon + 6'd1;
              end
            end else begin
              cal_d.day = cal_q.day + 5'd1;
            end
          end else begin
            cal_d.hr = cal_q.hr + 5'd1;
          end
        end else begin
          cal_d.min = cal_q.min + 6'd1;
        end
      end else begin
        cal_d.sec = cal_q.sec + 6'd1;
      end
    end
    if (ld_cal_i) cal_d = cal_i;
    if (ld_yr_i)  yr_d  = yr_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cal_q <= CAL_RESET;
      yr_q  <= YEAR_RESET;
    end else begin
      cal_q <= cal_d;
      yr_q  <= yr_d;
    end
  end

  assign cal_o = cal_q;
  assign yr_o  = yr_q;

  a_r8_sec_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !ld_cal_i && cal_q.sec == 6'd59) |=> (cal_q.sec == 6'd0));
  a_r8_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!adv_i && !ld_cal_i) |=> $stable(cal_q));
  a_r9_year_carry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !ld_cal_i && !ld_yr_i && cal_q.mon == 6'd12 && cal_q.day == 5'd31 &&
     cal_q.hr == 5'd23 && cal_q.min == 6'd59 && cal_q.sec == 6'd59)
    |=> (yr_q == $past(yr_q) + 32'd1) && (cal_q.mon == 6'd1) && (cal_q.day == 5'd1));
endmodule

// File: rtl/toy_clock.sv
module toy_clock
  import toy_clock_pkg::*;
#(
  parameter int unsigned TRIM_W     = 16,
  parameter int unsigned SYNC_TICKS = 2
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        osc_tick_i,
  input  logic        req_i,
  input  logic        we_i,
  input  logic [5:0]  addr_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o
);
  localparam int unsigned XW = 33;

  logic wr_trim, wr_cal, wr_yr, rd_cal;
  assign wr_trim = req_i && we_i && (addr_i == OFF_TRIM);
  assign wr_cal  = req_i && we_i && (addr_i == OFF_CAL_WR);
  assign wr_yr   = req_i && we_i && (addr_i == OFF_YR_WR);
  assign rd_cal  = req_i && !we_i && (addr_i == OFF_CAL_RD);

  logic              trim_busy, trim_load;
  logic [TRIM_W-1:0] trim_pend;
  toy_clock_xfer #(.W(TRIM_W), .SYNC_TICKS(SYNC_TICKS)) u_trim_xfer (
    .clk_i, .rst_ni,
    .wr_i(wr_trim), .wdata_i(wdata_i[TRIM_W-1:0]), .tick_i(osc_tick_i),
    .busy_o(trim_busy), .load_o(trim_load), .data_o(trim_pend)
  );

  logic          time_busy, time_load;
  logic [XW-1:0] time_pend;
  toy_clock_xfer #(.W(XW), .SYNC_TICKS(SYNC_TICKS)) u_time_xfer (
    .clk_i, .rst_ni,
    .wr_i(wr_cal || wr_yr), .wdata_i({wr_yr, wdata_i}), .tick_i(osc_tick_i),
    .busy_o(time_busy), .load_o(time_load), .data_o(time_pend)
  );

  logic [TRIM_W-1:0] trim_q;
  logic              run_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trim_q <= '0;
      run_q  <= 1'b0;
    end else if (trim_load) begin
      trim_q <= trim_pend;
      run_q  <= 1'b1;
    end
  end

  logic sec_pulse;
  toy_clock_prescaler #(.TRIM_W(TRIM_W)) u_presc (
    .clk_i, .rst_ni,
    .tick_i(osc_tick_i), .en_i(run_q), .load_i(trim_load), .trim_i(trim_q),
    .sec_o(sec_pulse)
  );

  cal_t        cal;
  logic [31:0] year;
  toy_clock_calendar u_cal (
    .clk_i, .rst_ni,
    .adv_i(sec_pulse),
    .ld_cal_i(time_load && !time_pend[XW-1]), .cal_i(cal_t'(time_pend[31:0])),
    .ld_yr_i(time_load && time_pend[XW-1]),   .yr_i(time_pend[31:0]),
    .cal_o(cal), .yr_o(year)
  );

  // year captured alongside each calendar read
  logic [31:0] yr_snap_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     yr_snap_q <= YEAR_RESET;
    else if (rd_cal) yr_snap_q <= year;
  end

  logic [31:0] stat;
  always_comb begin
    stat               = '0;
    stat[ST_TIME_BUSY] = time_busy;
    stat[ST_TRIM_BUSY] = trim_busy;
    stat[ST_OSC_OK]    = run_q;
    stat[ST_RUN]       = run_q;
  end

  always_comb begin
    unique case (addr_i)
      OFF_TRIM:   rdata_o = 32'(trim_q);
      OFF_CAL_RD: rdata_o = cal;
      OFF_YR_RD:  rdata_o = yr_snap_q;
      OFF_STAT:   rdata_o = stat;
      default:    rdata_o = '0;
    endcase
  end

  a_r1_stopped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_q |-> !sec_pulse);
  a_r4_run_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |=> run_q);
  a_r10_snap_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_cal |=> $stable(yr_snap_q));
endmodule

// File: tb/toy_clock_test.sv
`timescale 1ns/1ps
module toy_clock_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0, req = 1'b0, we = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  toy_clock uut (
    .clk_i(clk), .rst_ni(rst_n), .osc_tick_i(tick), .req_i(req), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata)
  );

  // reference model
  int m_sec, m_min, m_hr, m_day, m_mon, m_pad, m_yr, m_snap;
  int m_trim, m_presc, m_tc, m_tpend, m_xc, m_xsel;
  bit m_en, m_tb, m_xb;
  logic [31:0] m_xdata;

  function automatic int mdays(int m, int y);
    bit lp = (y % 4 == 0) && ((y % 100 != 0) || (y % 400 == 0));
    if (m == 2) return lp ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  function automatic logic [31:0] pack(int mo, int d, int h, int mi, int s);
    return (32'(mo) << 26) | (32'(d) << 21) | (32'(h) << 16) | (32'(mi) << 10) | (32'(s) << 4);
  endfunction

  function automatic logic [31:0] m_read(logic [5:0] a);
    case (a)
      6'h00: return 32'(m_trim);
      6'h0C: return pack(m_mon, m_day, m_hr, m_min, m_sec) | 32'(m_pad);
      6'h10: return 32'(m_yr == m_yr ? m_snap : 0);
      6'h20: return (32'(m_en) << 8) | (32'(m_en) << 5) | (32'(m_tb) << 4) | 32'(m_xb);
      default: return 32'd0;
    endcase
  endfunction

  function automatic string tag(logic [5:0] a);
    case (a)
      6'h0C: return "R3";
      6'h10: return "R10";
      6'h20: return "R5";
      default: return "R2";
    endcase
  endfunction

  task automatic model_reset();
    m_sec = 0; m_min = 0; m_hr = 0; m_day = 1; m_mon = 1; m_pad = 0; m_yr = 1900; m_snap = 1900;
    m_trim = 0; m_presc = 0; m_en = 0; m_tb = 0; m_tc = 0; m_tpend = 0;
    m_xb = 0; m_xc = 0; m_xsel = 0; m_xdata = '0;
  endtask

  task automatic model_step();
    bit tl, xl, adv;
    tl  = m_tb && tick && m_tc == 1;
    xl  = m_xb && tick && m_xc == 1;
    adv = m_en && tick && !tl && m_presc == m_trim;
    if (req && !we && addr == 6'h0C) m_snap = m_yr;
    if (tl) m_presc = 0;
    else if (m_en && tick) m_presc = adv ? 0 : m_presc + 1;
    if (adv) begin
      m_sec++;
      if (m_sec > 59) begin
        m_sec = 0; m_min++;
        if (m_min > 59) begin
          m_min = 0; m_hr++;
          if (m_hr > 23) begin
            m_hr = 0; m_day++;
            if (m_day > mdays(m_mon, m_yr)) begin
              m_day = 1; m_mon++;
              if (m_mon > 12) begin m_mon = 1; m_yr++; end
            end
          end
        end
      end
    end
    if (xl) begin
      if (m_xsel != 0) m_yr = int'(m_xdata);
      else begin
        m_mon = int'((m_xdata >> 26) & 32'h3f); m_day = int'((m_xdata >> 21) & 32'h1f);
        m_hr  = int'((m_xdata >> 16) & 32'h1f); m_min = int'((m_xdata >> 10) & 32'h3f);
        m_sec = int'((m_xdata >> 4) & 32'h3f);  m_pad = int'(m_xdata & 32'hf);
      end
    end
    if (tl) begin m_trim = m_tpend; m_en = 1; end
    if (tl) m_tb = 0;
    else if (m_tb) begin if (tick) m_tc++; end
    else if (req && we && addr == 6'h00) begin m_tb = 1; m_tc = 0; m_tpend = int'(wdata & 32'hffff); end
    if (xl) m_xb = 0;
    else if (m_xb) begin if (tick) m_xc++; end
    else if (req && we && (addr == 6'h04 || addr == 6'h08)) begin
      m_xb = 1; m_xc = 0; m_xsel = (addr == 6'h08); m_xdata = wdata;
    end
  endtask

  task automatic check(string r, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", r, act, exp, $time);
    end
  endtask

  initial model_reset();
  always @(posedge clk) begin
    if (rst_n) begin
      model_step();
      #2;
      if (!done) check(tag(addr), rdata, m_read(addr));
    end
  end

  task automatic bus_wr(logic [5:0] a, logic [31:0] d);
    @(negedge clk); req = 1; we = 1; addr = a; wdata = d;
    @(negedge clk); req = 0; we = 0;
  endtask

  task automatic bus_rd(logic [5:0] a, output logic [31:0] d);
    @(negedge clk); req = 1; we = 0; addr = a;
    #2 d = rdata;
    @(negedge clk); req = 0;
  endtask

  task automatic tick_n(int k, int gap = 0);
    for (int i = 0; i < k; i++) begin
      @(negedge clk) tick = 1;
      @(negedge clk) tick = 0;
      repeat (gap) @(negedge clk);
    end
  endtask

  task automatic set_time(int y, logic [31:0] c);
    bus_wr(6'h08, 32'(y)); tick_n(2);
    bus_wr(6'h04, c);      tick_n(2);
  endtask

  task automatic finish_run();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] v, c0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    bus_rd(6'h0C, v); check("R1", v, 32'h0420_0000);
    bus_rd(6'h10, v); check("R1", v, 32'd1900);
    bus_rd(6'h20, v); check("R1", v, 32'h0);
    tick_n(5);
    bus_rd(6'h0C, v); check("R1", v, 32'h0420_0000);
    // R4/R5 trim 3, second write while busy dropped
    bus_wr(6'h00, 32'd3);
    bus_rd(6'h20, v); check("R5", v, 32'h10);
    bus_wr(6'h00, 32'd7);
    tick_n(2);
    bus_rd(6'h20, v); check("R4", v, 32'h120);
    bus_rd(6'h00, v); check("R5", v, 32'd3);
    tick_n(3);
    bus_rd(6'h0C, v); check("R4", v, 32'h0420_0000);
    tick_n(1);
    bus_rd(6'h0C, v); check("R4", v, 32'h0420_0010);
    bus_wr(6'h00, 32'd0); tick_n(2);
    // R6/R7 time write
    bus_wr(6'h08, 32'd1999); tick_n(2);
    bus_wr(6'h04, pack(12, 31, 23, 59, 58));
    bus_rd(6'h20, v); check("R6", v, 32'h121);
    bus_wr(6'h08, 32'd2050);
    tick_n(2);
    bus_rd(6'h20, v); check("R6", v, 32'h120);
    bus_rd(6'h0C, v); check("R6", v, pack(12, 31, 23, 59, 58));
    bus_rd(6'h10, v); check("R7", v, 32'd1999);
    // R9/R10 year end and coherent snapshot
    tick_n(1);
    bus_rd(6'h0C, v); check("R8", v, pack(12, 31, 23, 59, 59));
    tick_n(1);
    bus_rd(6'h10, v); check("R10", v, 32'd1999);
    bus_rd(6'h0C, v); check("R9", v, 32'h0420_0000);
    bus_rd(6'h10, v); check("R9", v, 32'd2000);
    // R9 month lengths and leap years
    set_time(2000, pack(2, 28, 23, 59, 59)); tick_n(1);
    bus_rd(6'h0C, v); check("R9", v, pack(2, 29, 0, 0, 0));
    set_time(2100, pack(2, 28, 23, 59, 59)); tick_n(1);
    bus_rd(6'h0C, v); check("R9", v, pack(3, 1, 0, 0, 0));
    set_time(2023, pack(2, 28, 23, 59, 59)); tick_n(1);
    bus_rd(6'h0C, v); check("R9", v, pack(3, 1, 0, 0, 0));
    set_time(2024, pack(2, 28, 23, 59, 59)); tick_n(1);
    bus_rd(6'h0C, v); check("R9", v, pack(2, 29, 0, 0, 0));
    tick_n(86399);
    bus_rd(6'h0C, v); check("R9", v, pack(2, 29, 23, 59, 59));
    tick_n(1);
    bus_rd(6'h0C, v); check("R9", v, pack(3, 1, 0, 0, 0));
    set_time(2023, pack(4, 30, 23, 59, 59)); tick_n(1);
    bus_rd(6'h0C, v); check("R9", v, pack(5, 1, 0, 0, 0));
    // R8 minute/hour carry; R3 low nibble kept
    set_time(2023, pack(6, 15, 10, 59, 59) | 32'h5); tick_n(1);
    bus_rd(6'h0C, v); check("R8", v, pack(6, 15, 11, 0, 0) | 32'h5);
    bus_rd(6'h10, v); check("R3", v, 32'd2023);
    // R2 reserved offsets
    bus_wr(6'h14, 32'hffff_ffff);
    bus_rd(6'h14, v); check("R2", v, 32'h0);
    bus_rd(6'h04, v); check("R2", v, 32'h0);
    bus_rd(6'h20, v); check("R2", v, 32'h120);
    bus_rd(6'h0C, v); check("R2", v, pack(6, 15, 11, 0, 0) | 32'h5);
    // R4 sparse ticks with trim 2
    bus_wr(6'h00, 32'd2); tick_n(2, 2);
    bus_rd(6'h0C, c0);
    tick_n(2, 3);
    bus_rd(6'h0C, v); check("R4", v, c0);
    tick_n(1, 3);
    bus_rd(6'h0C, v); check("R4", v, c0 + 32'h10);
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule